// File: doc/BRIEF.md
# Serial Eight-Point DCT Sequencer

This block computes an eight-point one-dimensional DCT on 18-bit floating-point samples. It has no arithmetic of its own. It keeps a bank of eight working registers, a product latch, an accumulator and an eight-entry result store. One adder, one subtractor and one multiplier sit outside the block, and the sequencer shares them across every step of the transform. Operands leave the block through registered ports. Each unit raises a done flag together with its result, and the sequencer waits for that flag before it latches the result. Because of this handshake, unit latency can differ from one unit to another and from one operation to the next.

After a start pulse, the block accepts eight samples, one for each cycle on which the valid strobe is high. It first runs a folding stage that forms the sum and the difference of each mirrored sample pair. It then forms each output coefficient as a four-term dot product of the folded values with cosine weights. The weights come from an internal table. Each finished coefficient is written to the result store. When the last coefficient is stored, a done pulse is raised, and the results can then be read by index.

The number format has a sign in bit 17, an exponent with bias 63 in bits 16:10, and a 10-bit fraction with a hidden leading one in bits 9:0.

Top module: `dct8_serial_seq`

## Requirements
- R1: After a start pulse in idle, the samples on the first eight cycles with `smp_valid_i` high are stored at working positions 0 to 7 in arrival order. The valid strobe is ignored while the block is idle and while it is computing.
- R2: For each pair k = 0..3, the adder and the subtractor receive `op_a_o` = position k and `op_b_o` = position 7-k. The subtractor computes `op_a_o` minus `op_b_o`. The sum replaces position k and the difference replaces position 7-k.
- R3: During each multiply, `coef_o` holds the 18-bit encoding of a(u)*cos(pi*(2k+1)*u/16), rounded to nearest. Here a(0) = sqrt(1/8) and a(u) = sqrt(2/8) for u > 0. The 32 multiplies run with u outer (0..7) and k inner (0..3).
- R4: Each unit enable stays high until that unit's done flag is sampled high, then drops on the next cycle. The adder and the subtractor in the folding stage may finish in either order.
- R5: Output u is the sum over k = 0..3 of coefficient(u,k) times an operand on `op_b_o`. That operand is folded position k for even u and folded position 7-k for odd u. The first product seeds the accumulator, and each later product is added by the adder with `op_a_o` = accumulator and `op_b_o` = product.
- R6: `done_o` is high for exactly one cycle after the eighth result is stored. Output u is then returned on `rd_data_o` one cycle after `rd_idx_i` = u.
- R7: A start pulse that arrives after loading has finished and before `done_o` does not restart the sequence and does not change any result.
- R8: A synchronous reset returns the block to idle. While reset is held, all unit enables and `done_o` are low and `rd_data_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, honoured only in idle |
| smp_valid_i | input | 1 | Sample strobe during loading |
| smp_data_i | input | 18 | Sample value |
| op_a_o | output | 18 | First operand latch (adder, subtractor) |
| op_b_o | output | 18 | Second operand latch (adder, subtractor, multiplier) |
| coef_o | output | 18 | Coefficient latch (multiplier) |
| add_en_o | output | 1 | Adder request, held until done |
| add_sum_i | input | 18 | Adder result |
| add_done_i | input | 1 | Adder done flag |
| sub_en_o | output | 1 | Subtractor request, held until done |
| sub_diff_i | input | 18 | Subtractor result |
| sub_done_i | input | 1 | Subtractor done flag |
| mul_en_o | output | 1 | Multiplier request, held until done |
| mul_prod_i | input | 18 | Multiplier result |
| mul_done_i | input | 1 | Multiplier done flag |
| done_o | output | 1 | One-cycle completion pulse |
| rd_idx_i | input | 3 | Result read index |
| rd_data_o | output | 18 | Registered result read data |

## Verification
The hardest case to reach is a folding step in which the adder and the subtractor finish on different cycles. Here one enable must drop while the other stays high, and neither result may be lost. The bench's unit models take a separate latency for each unit. Sweeping these latencies makes the adder finish first, the subtractor finish first, and both finish together. The bench also raises a start pulse in the middle of a computation and applies a reset in the middle of a run, then checks that the results of the next run are still correct.

// File: rtl/dct8_seq_pkg.sv
package dct8_seq_pkg;

  localparam int NPT   = 8;
  localparam int FP_W  = 18;

  typedef enum logic [3:0] {
    S_IDLE, S_LOAD, S_BF_SEL, S_BF_RUN, S_BF_WB,
    S_MU_SEL, S_MU_RUN, S_MU_WB, S_AC_SEL, S_AC_RUN, S_AC_WB,
    S_STORE, S_FIN
  } seq_state_t;

  // Magnitude of 0.5*cos(i*pi/16) as sign-less exponent/fraction (bias 63).
  function automatic logic [16:0] cos_mag(input logic [2:0] i);
    case (i)
      3'd0: cos_mag = 17'h0F800;
      3'd1: cos_mag = 17'h0F7D9;
      3'd2: cos_mag = 17'h0F764;
      3'd3: cos_mag = 17'h0F6A7;
      3'd4: cos_mag = 17'h0F5A8;
      3'd5: cos_mag = 17'h0F472;
      3'd6: cos_mag = 17'h0F21F;
      default: cos_mag = 17'h0EE3E;
    endcase
  endfunction

  // Scaled cosine weight for output u, folded index k.
  function automatic logic [FP_W-1:0] dct8_coef(input logic [2:0] u, input logic [1:0] k);
    int n;
    logic neg;
    logic [16:0] mag;
    neg = 1'b0;
    if (u == 3'd0) begin
      mag = cos_mag(3'd4);
    end else begin
      n = ((2 * int'(k) + 1) * int'(u)) % 32;
      if (n > 16) n = 32 - n;
      if (n > 8) begin
        neg = 1'b1;
        n = 16 - n;
      end
      mag = cos_mag(3'(n));
    end
    return {neg, mag};
  endfunction

endpackage

// File: rtl/dct8_coef_rom.sv
module dct8_coef_rom
  import dct8_seq_pkg::*;
#(
  parameter int N  = NPT,
  parameter int DW = FP_W,
  localparam int AW = $clog2(N),
  localparam int KW = $clog2(N / 2)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [AW-1:0] u,
  input  logic [KW-1:0] k,
  output logic [DW-1:0] coef_q
);

  logic [DW-1:0] coef_d;

  always_comb coef_d = DW'(dct8_coef(3'(u), 2'(k)));

  always_ff @(posedge clk) begin
    if (rst)     coef_q <= '0;
    else if (en) coef_q <= coef_d;
  end

endmodule

// File: rtl/dct8_reg_bank.sv
module dct8_reg_bank #(
  parameter int N  = 8,
  parameter int DW = 18,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_we,
  input  logic [AW-1:0] ld_idx,
  input  logic [DW-1:0] ld_data,
  input  logic          pr_we,
  input  logic [AW-1:0] pr_lo,
  input  logic [AW-1:0] pr_hi,
  input  logic [DW-1:0] pr_lo_data,
  input  logic [DW-1:0] pr_hi_data,
  input  logic [AW-1:0] sel_a,
  input  logic [AW-1:0] sel_b,
  output logic [DW-1:0] rd_a,
  output logic [DW-1:0] rd_b
);

  logic [DW-1:0] w_q [N];

  for (genvar i = 0; i < N; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)                                 w_q[i] <= '0;
      else if (ld_we && ld_idx == AW'(i))      w_q[i] <= ld_data;
      else if (pr_we && pr_lo == AW'(i))       w_q[i] <= pr_lo_data;
      else if (pr_we && pr_hi == AW'(i))       w_q[i] <= pr_hi_data;
    end
  end

  always_comb begin
    rd_a = w_q[sel_a];
    rd_b = w_q[sel_b];
  end

  // R2
  pair_distinct_chk: assert property (@(posedge clk) disable iff (rst)
    pr_we |-> (pr_lo != pr_hi));

  // R1
  load_excl_chk: assert property (@(posedge clk) disable iff (rst)
    ld_we |-> !pr_we);

endmodule

// File: rtl/dct8_result_mem.sv
module dct8_result_mem #(
  parameter int N  = 8,
  parameter int DW = 18,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [N];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= mem[raddr];
  end

endmodule

// File: rtl/dct8_seq_ctrl.sv
module dct8_seq_ctrl
  import dct8_seq_pkg::*;
#(
  parameter int N = NPT,
  localparam int AW = $clog2(N),
  localparam int KW = $clog2(N / 2),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic          smp_valid_i,
  input  logic          add_done_i,
  input  logic          sub_done_i,
  input  logic          mul_done_i,
  output logic          ld_we_o,
  output logic [AW-1:0] ld_idx_o,
  output logic          pr_we_o,
  output logic [AW-1:0] pr_lo_o,
  output logic [AW-1:0] pr_hi_o,
  output logic [AW-1:0] sel_a_o,
  output logic [AW-1:0] sel_b_o,
  output logic          opl_en_o,
  output logic          accl_en_o,
  output logic          coef_en_o,
  output logic [AW-1:0] u_o,
  output logic [KW-1:0] k_o,
  output logic          add_en_o,
  output logic          sub_en_o,
  output logic          mul_en_o,
  output logic          sum_cap_o,
  output logic          dif_cap_o,
  output logic          prod_cap_o,
  output logic          acc_we_o,
  output logic          acc_from_mul_o,
  output logic          res_we_o,
  output logic          done_o
);

  seq_state_t    state_q;
  logic [CW-1:0] cnt_q;
  logic [KW-1:0] k_q;
  logic [AW-1:0] u_q;
  logic          got_add_q, got_sub_q;
  logic [AW-1:0] k_lo, k_hi, dot_idx;
  logic          pair_ok;

  always_comb begin
    k_lo    = AW'(k_q);
    k_hi    = AW'(N - 1) - k_lo;
    dot_idx = u_q[0] ? k_hi : k_lo;
    pair_ok = (got_add_q || add_done_i) && (got_sub_q || sub_done_i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= S_IDLE;
      cnt_q     <= '0;
      k_q       <= '0;
      u_q       <= '0;
      got_add_q <= 1'b0;
      got_sub_q <= 1'b0;
    end else begin
      case (state_q)
        S_IDLE: if (start_i) begin
          state_q <= S_LOAD;
          cnt_q   <= '0;
        end
        S_LOAD: if (smp_valid_i) begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CW'(N - 1)) begin
            state_q <= S_BF_SEL;
            k_q     <= '0;
          end
        end
        S_BF_SEL: state_q <= S_BF_RUN;
        S_BF_RUN: begin
          if (pair_ok) begin
            state_q   <= S_BF_WB;
            got_add_q <= 1'b0;
            got_sub_q <= 1'b0;
          end else begin
            got_add_q <= got_add_q | add_done_i;
            got_sub_q <= got_sub_q | sub_done_i;
          end
        end
        S_BF_WB: begin
          k_q <= k_q + 1'b1;
          if (k_q == KW'(N / 2 - 1)) begin
            state_q <= S_MU_SEL;
            u_q     <= '0;
          end else begin
            state_q <= S_BF_SEL;
          end
        end
        S_MU_SEL: state_q <= S_MU_RUN;
        S_MU_RUN: if (mul_done_i) state_q <= S_MU_WB;
        S_MU_WB: begin
          if (k_q == '0) begin
            k_q     <= k_q + 1'b1;
            state_q <= S_MU_SEL;
          end else begin
            state_q <= S_AC_SEL;
          end
        end
        S_AC_SEL: state_q <= S_AC_RUN;
        S_AC_RUN: if (add_done_i) state_q <= S_AC_WB;
        S_AC_WB: begin
          k_q     <= k_q + 1'b1;
          state_q <= (k_q == KW'(N / 2 - 1)) ? S_STORE : S_MU_SEL;
        end
        S_STORE: begin
          u_q     <= u_q + 1'b1;
          state_q <= (u_q == AW'(N - 1)) ? S_FIN : S_MU_SEL;
        end
        S_FIN:   state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    ld_we_o        = (state_q == S_LOAD) && smp_valid_i;
    ld_idx_o       = cnt_q[AW-1:0];
    pr_we_o        = (state_q == S_BF_WB);
    pr_lo_o        = k_lo;
    pr_hi_o        = k_hi;
    sel_a_o        = k_lo;
    sel_b_o        = (state_q == S_MU_SEL) ? dot_idx : k_hi;
    opl_en_o       = (state_q == S_BF_SEL) || (state_q == S_MU_SEL);
    accl_en_o      = (state_q == S_AC_SEL);
    coef_en_o      = (state_q == S_MU_SEL);
    u_o            = u_q;
    k_o            = k_q;
    add_en_o       = ((state_q == S_BF_RUN) && !got_add_q) || (state_q == S_AC_RUN);
    sub_en_o       = (state_q == S_BF_RUN) && !got_sub_q;
    mul_en_o       = (state_q == S_MU_RUN);
    sum_cap_o      = add_en_o && add_done_i;
    dif_cap_o      = sub_en_o && sub_done_i;
    prod_cap_o     = mul_en_o && mul_done_i;
    acc_we_o       = ((state_q == S_MU_WB) && (k_q == '0)) || (state_q == S_AC_WB);
    acc_from_mul_o = (state_q == S_MU_WB);
    res_we_o       = (state_q == S_STORE);
    done_o         = (state_q == S_FIN);
  end

  // R4
  add_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (add_en_o && !add_done_i) |=> add_en_o);
  // R4
  sub_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (sub_en_o && !sub_done_i) |=> sub_en_o);
  // R4
  mul_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mul_en_o && !mul_done_i) |=> mul_en_o);
  // R4
  mul_alone_chk: assert property (@(posedge clk) disable iff (rst)
    mul_en_o |-> !(add_en_o || sub_en_o));
  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  // R7
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    (start_i && state_q != S_IDLE && state_q != S_LOAD) |=> (state_q != S_LOAD));
  // R1
  load_count_chk: assert property (@(posedge clk) disable iff (rst)
    ld_we_o |-> (cnt_q < CW'(N)));

endmodule

// File: rtl/dct8_serial_seq.sv
module dct8_serial_seq
  import dct8_seq_pkg::*;
#(
  parameter int N  = NPT,
  parameter int DW = FP_W,
  localparam int AW = $clog2(N),
  localparam int KW = $clog2(N / 2)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic          smp_valid_i,
  input  logic [DW-1:0] smp_data_i,
  output logic [DW-1:0] op_a_o,
  output logic [DW-1:0] op_b_o,
  output logic [DW-1:0] coef_o,
  output logic          add_en_o,
  input  logic [DW-1:0] add_sum_i,
  input  logic          add_done_i,
  output logic          sub_en_o,
  input  logic [DW-1:0] sub_diff_i,
  input  logic          sub_done_i,
  output logic          mul_en_o,
  input  logic [DW-1:0] mul_prod_i,
  input  logic          mul_done_i,
  output logic          done_o,
  input  logic [AW-1:0] rd_idx_i,
  output logic [DW-1:0] rd_data_o
);

  logic          ld_we, pr_we, opl_en, accl_en, coef_en;
  logic          sum_cap, dif_cap, prod_cap, acc_we, acc_from_mul, res_we;
  logic [AW-1:0] ld_idx, pr_lo, pr_hi, sel_a, sel_b, u_idx;
  logic [KW-1:0] k_idx;
  logic [DW-1:0] rd_a, rd_b, sum_q, dif_q, prod_q, acc_q, acc_d;

  dct8_seq_ctrl #(.N(N)) ctrl_i (
    .clk(clk), .rst(rst), .start_i(start_i), .smp_valid_i(smp_valid_i),
    .add_done_i(add_done_i), .sub_done_i(sub_done_i), .mul_done_i(mul_done_i),
    .ld_we_o(ld_we), .ld_idx_o(ld_idx), .pr_we_o(pr_we), .pr_lo_o(pr_lo), .pr_hi_o(pr_hi),
    .sel_a_o(sel_a), .sel_b_o(sel_b), .opl_en_o(opl_en), .accl_en_o(accl_en),
    .coef_en_o(coef_en), .u_o(u_idx), .k_o(k_idx),
    .add_en_o(add_en_o), .sub_en_o(sub_en_o), .mul_en_o(mul_en_o),
    .sum_cap_o(sum_cap), .dif_cap_o(dif_cap), .prod_cap_o(prod_cap),
    .acc_we_o(acc_we), .acc_from_mul_o(acc_from_mul), .res_we_o(res_we), .done_o(done_o)
  );

  dct8_reg_bank #(.N(N), .DW(DW)) bank_i (
    .clk(clk), .rst(rst), .ld_we(ld_we), .ld_idx(ld_idx), .ld_data(smp_data_i),
    .pr_we(pr_we), .pr_lo(pr_lo), .pr_hi(pr_hi), .pr_lo_data(sum_q), .pr_hi_data(dif_q),
    .sel_a(sel_a), .sel_b(sel_b), .rd_a(rd_a), .rd_b(rd_b)
  );

  dct8_coef_rom #(.N(N), .DW(DW)) rom_i (
    .clk(clk), .rst(rst), .en(coef_en), .u(u_idx), .k(k_idx), .coef_q(coef_o)
  );

  dct8_result_mem #(.N(N), .DW(DW)) res_i (
    .clk(clk), .rst(rst), .we(res_we), .waddr(u_idx), .wdata(acc_q),
    .raddr(rd_idx_i), .rdata(rd_data_o)
  );

  // Write-back selector: product seeds the accumulator, sums update it.
  always_comb acc_d = acc_from_mul ? prod_q : sum_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      op_a_o <= '0;
      op_b_o <= '0;
      sum_q  <= '0;
      dif_q  <= '0;
      prod_q <= '0;
      acc_q  <= '0;
    end else begin
      if (opl_en) begin
        op_a_o <= rd_a;
        op_b_o <= rd_b;
      end else if (accl_en) begin
        op_a_o <= acc_q;
        op_b_o <= prod_q;
      end
      if (sum_cap)  sum_q  <= add_sum_i;
      if (dif_cap)  dif_q  <= sub_diff_i;
      if (prod_cap) prod_q <= mul_prod_i;
      if (acc_we)   acc_q  <= acc_d;
    end
  end

  // R3
  mul_operand_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (mul_en_o && !mul_done_i) |=> ($stable(coef_o) && $stable(op_b_o)));

  // R2
  add_operand_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (add_en_o && !add_done_i) |=> ($stable(op_a_o) && $stable(op_b_o)));

endmodule

// File: tb/dct8_serial_seq_tb_top.sv
module dct8_serial_seq_tb_top;

  localparam real PI = 3.14159265358979;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic        smp_valid_i = 1'b0;
  logic [17:0] smp_data_i = '0;
  logic [17:0] op_a_o, op_b_o, coef_o, rd_data_o;
  logic        add_en_o, sub_en_o, mul_en_o, done_o;
  logic [17:0] add_sum_i = '0, sub_diff_i = '0, mul_prod_i = '0;
  logic        add_done_i = 1'b0, sub_done_i = 1'b0, mul_done_i = 1'b0;
  logic [2:0]  rd_idx_i = '0;

  int checks = 0;
  int failures = 0;
  int alat = 0, slat = 0, mlat = 0;
  int acnt = 0, scnt = 0, mcnt = 0;
  int mstep = 0;
  logic add_en_p = 1'b0, sub_en_p = 1'b0, mul_en_p = 1'b0;
  logic add_dn_p = 1'b0, sub_dn_p = 1'b0, mul_dn_p = 1'b0;
  logic [17:0] xin [8];
  logic [17:0] ecoef [32];

  always #4 clk = ~clk;

  dct8_serial_seq dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .smp_valid_i(smp_valid_i), .smp_data_i(smp_data_i),
    .op_a_o(op_a_o), .op_b_o(op_b_o), .coef_o(coef_o),
    .add_en_o(add_en_o), .add_sum_i(add_sum_i), .add_done_i(add_done_i),
    .sub_en_o(sub_en_o), .sub_diff_i(sub_diff_i), .sub_done_i(sub_done_i),
    .mul_en_o(mul_en_o), .mul_prod_i(mul_prod_i), .mul_done_i(mul_done_i),
    .done_o(done_o), .rd_idx_i(rd_idx_i), .rd_data_o(rd_data_o)
  );

  task automatic chk(input bit ok, input string req, input logic [17:0] act, input logic [17:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [17:0] fp_enc(input real v);
    logic s;
    real a;
    int e, f;
    s = (v < 0.0);
    a = s ? -v : v;
    e = 0;
    while (a < 1.0) begin a = a * 2.0; e--; end
    while (a >= 2.0) begin a = a / 2.0; e++; end
    f = $rtoi((a - 1.0) * 1024.0 + 0.5);
    if (f == 1024) begin f = 0; e++; end
    return {s, 7'(e + 63), 10'(f)};
  endfunction

  function automatic logic [17:0] mul18(input logic [17:0] a, input logic [17:0] b);
    logic [35:0] p;
    p = 36'(a) * 36'(b);
    return p[17:0];
  endfunction

  function automatic logic [17:0] exp_f(input int u);
    logic [17:0] acc, opnd;
    acc = '0;
    for (int k = 0; k < 4; k++) begin
      opnd = (u % 2 == 1) ? 18'(xin[k] - xin[7-k]) : 18'(xin[k] + xin[7-k]);
      acc  = 18'(acc + mul18(ecoef[u*4+k], opnd));
    end
    return acc;
  endfunction

  // Adder model: latency alat, checks hold/release of its enable (R4)
  always @(negedge clk) begin
    if (!rst && add_en_p && !add_dn_p) chk(add_en_o, "R4 add enable held", {17'b0, add_en_o}, 18'd1);
    if (!rst && add_dn_p) chk(!add_en_o, "R4 add enable released", {17'b0, add_en_o}, 18'd0);
    add_en_p = add_en_o;
    add_done_i = 1'b0;
    if (add_en_o && !rst) begin
      if (acnt >= alat) begin
        add_done_i = 1'b1;
        add_sum_i  = 18'(op_a_o + op_b_o);
        acnt = 0;
      end else acnt++;
    end else acnt = 0;
    add_dn_p = add_done_i;
  end

  always @(negedge clk) begin
    if (!rst && sub_en_p && !sub_dn_p) chk(sub_en_o, "R4 sub enable held", {17'b0, sub_en_o}, 18'd1);
    if (!rst && sub_dn_p) chk(!sub_en_o, "R4 sub enable released", {17'b0, sub_en_o}, 18'd0);
    sub_en_p = sub_en_o;
    sub_done_i = 1'b0;
    if (sub_en_o && !rst) begin
      if (scnt >= slat) begin
        sub_done_i = 1'b1;
        sub_diff_i = 18'(op_a_o - op_b_o);
        scnt = 0;
      end else scnt++;
    end else scnt = 0;
    sub_dn_p = sub_done_i;
  end

  // Multiplier model: also checks each coefficient in schedule order (R3)
  always @(negedge clk) begin
    if (!rst && mul_en_o && !mul_en_p) begin
      if (mstep < 32) chk(coef_o == ecoef[mstep], "R3 coefficient", coef_o, ecoef[mstep]);
      mstep++;
    end
    if (!rst && mul_dn_p) chk(!mul_en_o, "R4 mul enable released", {17'b0, mul_en_o}, 18'd0);
    mul_en_p = mul_en_o;
    mul_done_i = 1'b0;
    if (mul_en_o && !rst) begin
      if (mcnt >= mlat) begin
        mul_done_i = 1'b1;
        mul_prod_i = mul18(coef_o, op_b_o);
        mcnt = 0;
      end else mcnt++;
    end else mcnt = 0;
    mul_dn_p = mul_done_i;
  end

  task automatic run_case(input int al, input int sl, input int ml, input bit busy_start);
    int dn;
    int cyc;
    alat = al; slat = sl; mlat = ml; mstep = 0;
    // R1: strobe in idle must be ignored
    @(negedge clk); smp_valid_i = 1'b1; smp_data_i = 18'h15555;
    @(negedge clk); smp_valid_i = 1'b0; start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    for (int i = 0; i < 8; i++) begin
      smp_valid_i = 1'b1; smp_data_i = xin[i];
      @(negedge clk);
    end
    // R1: strobe during compute must be ignored
    smp_data_i = 18'h2AAAA;
    for (int i = 0; i < 3; i++) @(negedge clk);
    smp_valid_i = 1'b0;
    dn = 0; cyc = 0;
    while (dn == 0 && cyc < 20000) begin
      if (done_o) dn++;
      start_i = (busy_start && cyc == 15);  // R7
      @(negedge clk);
      cyc++;
    end
    start_i = 1'b0;
    for (int i = 0; i < 4; i++) begin
      if (done_o) dn++;
      @(negedge clk);
    end
    chk(dn == 1, "R6 single done pulse", 18'(dn), 18'd1);
    chk(mstep == 32, "R3 multiply count", 18'(mstep), 18'd32);
    for (int u = 0; u < 8; u++) begin
      rd_idx_i = 3'(u);
      @(negedge clk);
      chk(rd_data_o == exp_f(u), busy_start ? "R7 R2 R5 R6 result" : "R1 R2 R4 R5 R6 result",
          rd_data_o, exp_f(u));
    end
  endtask

  initial begin
    #(8 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int u = 0; u < 8; u++)
      for (int k = 0; k < 4; k++)
        ecoef[u*4+k] = fp_enc(((u == 0) ? $sqrt(1.0/8.0) : $sqrt(2.0/8.0)) *
                              $cos(PI * real'(2*k+1) * real'(u) / 16.0));
    // R8: state while reset is held
    repeat (3) @(negedge clk);
    chk(!done_o, "R8 done low in reset", {17'b0, done_o}, 18'd0);
    chk(!(add_en_o || sub_en_o || mul_en_o), "R8 enables low in reset",
        {15'b0, add_en_o, sub_en_o, mul_en_o}, 18'd0);
    chk(rd_data_o == 18'd0, "R8 read data zero in reset", rd_data_o, 18'd0);
    rst = 1'b0;

    for (int i = 0; i < 8; i++) xin[i] = 18'(i + 1);
    run_case(0, 0, 0, 1'b0);
    for (int i = 0; i < 8; i++) xin[i] = 18'h3FFFF;
    run_case(1, 3, 2, 1'b0);   // R4: adder before subtractor
    for (int i = 0; i < 8; i++) xin[i] = 18'(i * 37 + 5) ^ 18'h0F0F0;
    run_case(4, 1, 0, 1'b0);   // R4: subtractor before adder
    for (int i = 0; i < 8; i++) xin[i] = (i % 2 == 0) ? 18'h1F800 : 18'h0F800;
    run_case(2, 2, 5, 1'b0);
    for (int i = 0; i < 8; i++) xin[i] = '0;
    run_case(0, 1, 1, 1'b0);
    for (int i = 0; i < 8; i++) xin[i] = 18'((i * 40503 + 12345) % 262144);
    run_case(3, 0, 2, 1'b1);   // R7: start during busy

    // R8: reset in the middle of a run, then a clean run
    alat = 2; slat = 2; mlat = 2;
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    for (int i = 0; i < 8; i++) begin
      smp_valid_i = 1'b1; smp_data_i = 18'h00777;
      @(negedge clk);
    end
    smp_valid_i = 1'b0;
    repeat (30) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(!(add_en_o || sub_en_o || mul_en_o), "R8 enables low after mid-run reset",
        {15'b0, add_en_o, sub_en_o, mul_en_o}, 18'd0);
    chk(!done_o, "R8 done low after mid-run reset", {17'b0, done_o}, 18'd0);
    chk(rd_data_o == 18'd0, "R8 read data zero after mid-run reset", rd_data_o, 18'd0);
    @(negedge clk); rst = 1'b0;
    for (int i = 0; i < 8; i++) xin[i] = 18'(3000 - i * 250);
    run_case(1, 0, 3, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule